// File: doc/BRIEF.md
# Dual-Bank 3x4 Color Matrix Converter

This block converts a stream of three-channel pixels from one color space to another. Each output channel is a signed weighted sum of the three input channels plus a constant term. The result is rounded to the nearest integer and clamped to the unsigned pixel range. Two full sets of twelve coefficients are held on chip. A mode field selects either set, or a pass-through path that returns the pixel unchanged. This lets software fill the idle set while the other one is in use, then switch between pixels.

A new pixel is accepted on every clock, with no handshake. Its result appears a fixed three cycles later. Configuration uses a single write port. One address sets the mode. Each of the other used addresses carries two adjacent coefficients of one set, packed into one data word. Coefficients are signed fixed point with 13 fractional bits. The fourth term of each row is an offset expressed as a fraction of full scale.

Top module: `csc3x4_top`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are 0 and the mode is pass-through. Both coefficient sets start as the identity matrix: code 0x2000 at row/column positions (1,1), (2,2) and (3,3), and every other coefficient 0.
- R2: A pixel presented before a rising clock edge appears on the outputs just after the third rising edge, counting that edge as the first. A new pixel may be presented every cycle.
- R3: Mode codes 0 and 3 pass each input channel to the output channel of the same number, unchanged.
- R4: Mode 1 uses set A and mode 2 uses set B. For row r, out_r = clamp(round((Cr1*in0 + Cr2*in1 + Cr3*in2 + Cr4*2^DATA_W) / 2^13)).
- R5: Coefficients are 16-bit two's-complement codes with 13 fractional bits, so 0x2000 is a gain of 1.0 and 0xF000 is a gain of -0.5.
- R6: Rounding adds 2^12 to the sum and then floors the result, so an exact half rounds upward.
- R7: A result below 0 becomes 0, and a result above 2^DATA_W-1 becomes 2^DATA_W-1.
- R8: Bit 3 of the address selects the set (0 = A, 1 = B). Bits 2:0, with values 0 to 5, select the pair in the order (C11,C12), (C13,C14), (C21,C22), (C23,C24), (C31,C32), (C33,C34). Data bits 15:0 hold the first coefficient of the pair and bits 31:16 the second.
- R9: Writes to addresses 6, 14 and 15 change neither coefficient set nor the mode.
- R10: A write to address 7 loads the mode from data bits 1:0.
- R11: A configuration write that is captured at a clock edge affects only pixels sampled at later edges. Pixels sampled at or before that edge finish with the settings in force when they were sampled.
- R12: The full-range BT.709 to RGB set {0x3265, 0x2000, 0, 0xE6CE, 0xF105, 0x2000, 0xFA01, 0x0A7D, 0, 0x2000, 0x3B61, 0xE24F}, given in row order, produces results that match the formula in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address (set bit and pair, or mode) |
| cfg_wdata | input | 32 | Configuration data: packed coefficient pair, or mode in bits 1:0 |
| pix_in0 | input | DATA_W | Input channel 0 |
| pix_in1 | input | DATA_W | Input channel 1 |
| pix_in2 | input | DATA_W | Input channel 2 |
| pix_out0 | output | DATA_W | Output channel 0 |
| pix_out1 | output | DATA_W | Output channel 1 |
| pix_out2 | output | DATA_W | Output channel 2 |

## Verification
Pass-through is tried with full-scale, zero and mid-range values in both pass codes. This shows that the bypass keeps each channel in its own lane. A reset-time identity matrix shows that each set starts with unity gain. A hand-built set B uses half gains, a small positive offset and a negative half offset. It separates round-half-up from truncation and exercises signed offsets and the low clamp. The BT.709 set, fed with gray, saturated and mixed pixels, exercises negative coefficients and both clamp limits. A one-pair overwrite shows which half of the data word lands on which coefficient. A back-to-back stream, and a mode change made while pixels are in flight, pin the three-cycle latency and the per-pixel capture of settings.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // structural constants of the 3x4 matrix
    localparam int NUM_ROWS  = 3;
    localparam int ROW_TERMS = 4;
    localparam int NUM_COEF  = NUM_ROWS * ROW_TERMS;
    localparam int NUM_PAIRS = NUM_COEF / 2;
    localparam int ADDR_W    = 4;
    localparam logic [ADDR_W-1:0] MODE_ADDR = 4'h7;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_BANK_A = 2'd1,
        MODE_BANK_B = 2'd2,
        MODE_SPARE  = 2'd3
    } csc_mode_e;

endpackage

// File: rtl/csc_coef_store.sv
module csc_coef_store
    import csc_pkg::*;
#(
    parameter int COEF_W    = 16,
    parameter int FRAC_W    = 13,
    parameter int NUM_BANKS = 2
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           wr_en,
    input  logic [$clog2(NUM_BANKS)-1:0]                   wr_bank,
    input  logic [$clog2(NUM_PAIRS)-1:0]                   wr_pair,
    input  logic [2*COEF_W-1:0]                            wr_data,
    output logic [NUM_BANKS-1:0][NUM_COEF-1:0][COEF_W-1:0] coef_o
);

    localparam int PAIR_W = $clog2(NUM_PAIRS);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    typedef logic [NUM_BANKS-1:0][NUM_COEF-1:0][COEF_W-1:0] store_t;

    store_t store_d, store_q, ident_w;

    // identity reset image: unity on the diagonal (flat index divisible by 5)
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef
            if ((k % (ROW_TERMS + 1)) == 0) begin : g_diag
                assign ident_w[b][k] = UNITY;
            end else begin : g_zero
                assign ident_w[b][k] = '0;
            end
        end
    end

    always_comb begin
        store_d = store_q;
        if (wr_en && (wr_pair <= LAST_PAIR)) begin
            store_d[wr_bank][{wr_pair, 1'b0}] = wr_data[COEF_W-1:0];
            store_d[wr_bank][{wr_pair, 1'b1}] = wr_data[2*COEF_W-1:COEF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= ident_w;
        end else begin
            store_q <= store_d;
        end
    end

    assign coef_o = store_q;

endmodule

// File: rtl/csc_row_mac.sv
module csc_row_mac
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 13
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bypass_i,
    input  logic [DATA_W-1:0]                     pass_i,
    input  logic [NUM_ROWS-1:0][DATA_W-1:0]       ch_i,
    input  logic [ROW_TERMS-1:0][COEF_W-1:0]      coef_i,
    output logic [DATA_W-1:0]                     out_o
);

    localparam int PROD_W = COEF_W + DATA_W + 1;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] HALF_LSB =
        {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX =
        {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

    typedef struct packed {
        // stage 1: products and offset
        logic                             byp1;
        logic [DATA_W-1:0]                pass1;
        logic [NUM_ROWS-1:0][PROD_W-1:0]  prod;
        logic [ACC_W-1:0]                 off;
        // stage 2: full-precision sum
        logic                             byp2;
        logic [DATA_W-1:0]                pass2;
        logic [ACC_W-1:0]                 acc;
        // stage 3: rounded and clamped result
        logic [DATA_W-1:0]                res;
    } row_state_t;

    row_state_t st_d, st_q;

    logic [PROD_W-1:0]        c_ext;
    logic [PROD_W-1:0]        d_ext;
    logic [ACC_W-1:0]         off_ext;
    logic [ACC_W-1:0]         sum;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  scaled;

    always_comb begin
        st_d = st_q;
        c_ext = '0;
        d_ext = '0;

        // stage 1
        st_d.byp1  = bypass_i;
        st_d.pass1 = pass_i;
        for (int k = 0; k < NUM_ROWS; k++) begin
            c_ext = {{(PROD_W-COEF_W){coef_i[k][COEF_W-1]}}, coef_i[k]};
            d_ext = {{(PROD_W-DATA_W){1'b0}}, ch_i[k]};
            st_d.prod[k] = c_ext * d_ext;
        end
        off_ext = {{(ACC_W-COEF_W){coef_i[ROW_TERMS-1][COEF_W-1]}}, coef_i[ROW_TERMS-1]};
        st_d.off = off_ext << DATA_W;

        // stage 2
        st_d.byp2  = st_q.byp1;
        st_d.pass2 = st_q.pass1;
        sum = st_q.off;
        for (int k = 0; k < NUM_ROWS; k++) begin
            sum = sum + {{(ACC_W-PROD_W){st_q.prod[k][PROD_W-1]}}, st_q.prod[k]};
        end
        st_d.acc = sum;

        // stage 3
        rounded = $signed(st_q.acc) + HALF_LSB;
        scaled  = rounded >>> FRAC_W;
        if (st_q.byp2) begin
            st_d.res = st_q.pass2;
        end else if (scaled < 0) begin
            st_d.res = '0;
        end else if (scaled > OUT_MAX) begin
            st_d.res = {DATA_W{1'b1}};
        end else begin
            st_d.res = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.res;

endmodule

// File: rtl/csc3x4_top.sv
module csc3x4_top
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [2*COEF_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0]   pix_in0,
    input  logic [DATA_W-1:0]   pix_in1,
    input  logic [DATA_W-1:0]   pix_in2,
    output logic [DATA_W-1:0]   pix_out0,
    output logic [DATA_W-1:0]   pix_out1,
    output logic [DATA_W-1:0]   pix_out2
);

    localparam int NUM_BANKS = 2;
    localparam int PAIR_W    = $clog2(NUM_PAIRS);
    localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

    typedef struct packed {
        csc_mode_e mode;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [1:0]                                     mode_q;
    logic                                           coef_we;
    logic [NUM_BANKS-1:0][NUM_COEF-1:0][COEF_W-1:0] coef_all;
    logic [NUM_COEF-1:0][COEF_W-1:0]                coef_sel;
    logic                                           bypass;
    logic [NUM_ROWS-1:0][DATA_W-1:0]                pix_w;
    logic [NUM_ROWS-1:0][DATA_W-1:0]                out_w;

    always_comb begin
        top_d = top_q;
        if (cfg_we && (cfg_addr == MODE_ADDR)) begin
            top_d.mode = csc_mode_e'(cfg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{mode: MODE_PASS};
        end else begin
            top_q <= top_d;
        end
    end

    assign mode_q  = top_q.mode;
    assign coef_we = cfg_we && (cfg_addr[PAIR_W-1:0] <= LAST_PAIR);

    csc_coef_store #(
        .COEF_W    (COEF_W),
        .FRAC_W    (FRAC_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_bank (cfg_addr[ADDR_W-1]),
        .wr_pair (cfg_addr[PAIR_W-1:0]),
        .wr_data (cfg_wdata),
        .coef_o  (coef_all)
    );

    always_comb begin
        coef_sel = (top_q.mode == MODE_BANK_B) ? coef_all[1] : coef_all[0];
        bypass   = (top_q.mode == MODE_PASS) || (top_q.mode == MODE_SPARE);
    end

    assign pix_w = {pix_in2, pix_in1, pix_in0};

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        csc_row_mac #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .FRAC_W (FRAC_W)
        ) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .bypass_i (bypass),
            .pass_i   (pix_w[r]),
            .ch_i     (pix_w),
            .coef_i   (coef_sel[ROW_TERMS*r+ROW_TERMS-1 -: ROW_TERMS]),
            .out_o    (out_w[r])
        );
    end

    assign pix_out0 = out_w[0];
    assign pix_out1 = out_w[1];
    assign pix_out2 = out_w[2];

endmodule

// File: rtl/csc3x4_chk.sv
module csc3x4_chk
    import csc_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic [ADDR_W-1:0]            cfg_addr,
    input logic [2*COEF_W-1:0]          cfg_wdata,
    input logic [DATA_W-1:0]            pix_in0,
    input logic [DATA_W-1:0]            pix_in1,
    input logic [DATA_W-1:0]            pix_in2,
    input logic [DATA_W-1:0]            pix_out0,
    input logic [DATA_W-1:0]            pix_out1,
    input logic [DATA_W-1:0]            pix_out2,
    input logic [1:0]                   mode_q,
    input logic [2*NUM_COEF*COEF_W-1:0] coef_flat
);

    // cycles since reset release, saturating at 3
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd0) |-> (pix_out0 == '0 && pix_out1 == '0 && pix_out2 == '0
                             && mode_q == 2'd0));

    p_pass_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && $past(mode_q == 2'd0 || mode_q == 2'd3, 3))
        |-> (pix_out0 == $past(pix_in0, 3) && pix_out1 == $past(pix_in1, 3)
             && pix_out2 == $past(pix_in2, 3)));

    p_mode_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && $past(cfg_we && cfg_addr == MODE_ADDR))
        |-> (mode_q == $past(cfg_wdata[1:0])));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && !$past(cfg_we && cfg_addr == MODE_ADDR))
        |-> $stable(mode_q));

    p_coef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && !$past(cfg_we && cfg_addr[2:0] < 3'd6))
        |-> $stable(coef_flat));

endmodule

bind csc3x4_top csc3x4_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pix_in0   (pix_in0),
    .pix_in1   (pix_in1),
    .pix_in2   (pix_in2),
    .pix_out0  (pix_out0),
    .pix_out1  (pix_out1),
    .pix_out2  (pix_out2),
    .mode_q    (mode_q),
    .coef_flat (coef_all)
);

// File: tb/csc3x4_top_tb.sv
module csc3x4_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 10;
    localparam int CW = 16;
    localparam int OMAX = (1 << DW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [3:0]      cfg_addr = '0;
    logic [2*CW-1:0] cfg_wdata = '0;
    logic [DW-1:0]   pix_in0 = '0, pix_in1 = '0, pix_in2 = '0;
    logic [DW-1:0]   pix_out0, pix_out1, pix_out2;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    // bench-side model of the configuration, built from the requirements
    int cf [2][12];
    int cur_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csc3x4_top #(.DATA_W(DW), .COEF_W(CW), .FRAC_W(13)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_in0(pix_in0), .pix_in1(pix_in1),
        .pix_in2(pix_in2), .pix_out0(pix_out0), .pix_out1(pix_out1),
        .pix_out2(pix_out2)
    );

    function automatic int exp_row(int m, int r, int a, int b, int c);
        longint acc;
        int bk;
        if (m == 0 || m == 3) return (r == 0) ? a : (r == 1) ? b : c;
        bk = (m == 2) ? 1 : 0;
        acc = longint'(cf[bk][4*r]) * a + longint'(cf[bk][4*r+1]) * b
            + longint'(cf[bk][4*r+2]) * c + longint'(cf[bk][4*r+3]) * (1 << DW);
        acc = (acc + 4096) >>> 13;
        if (acc < 0) return 0;
        if (acc > OMAX) return OMAX;
        return int'(acc);
    endfunction

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic cfg_write(logic [3:0] addr, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr == 4'h7) cur_mode = int'(data[1:0]);
        else if (addr[2:0] < 3'd6) begin
            cf[addr[3]][2*addr[2:0]]   = int'($signed(data[15:0]));
            cf[addr[3]][2*addr[2:0]+1] = int'($signed(data[31:16]));
        end
    endtask

    // one pixel through the pipe, compared with hand values
    task automatic px_exp(string tag, int a, int b, int c, int e0, int e1, int e2);
        @(negedge clk);
        pix_in0 = DW'(a); pix_in1 = DW'(b); pix_in2 = DW'(c);
        repeat (3) @(negedge clk);
        chk({tag, " ch0"}, int'(pix_out0), e0);
        chk({tag, " ch1"}, int'(pix_out1), e1);
        chk({tag, " ch2"}, int'(pix_out2), e2);
    endtask

    // one pixel through the pipe, compared with the formula model
    task automatic px(string tag, int a, int b, int c);
        px_exp(tag, a, b, c, exp_row(cur_mode, 0, a, b, c),
               exp_row(cur_mode, 1, a, b, c), exp_row(cur_mode, 2, a, b, c));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset out0", int'(pix_out0), 0);
        chk("R1 reset out1", int'(pix_out1), 0);
        chk("R1 reset out2", int'(pix_out2), 0);
        px_exp("R1 pass after reset", 5, 6, 7, 5, 6, 7);
        cfg_write(4'h7, 32'd1);
        px_exp("R1 R4 set A identity", 100, 200, 300, 100, 200, 300);
        cfg_write(4'h7, 32'd2);
        px_exp("R1 R4 set B identity", 1023, 0, 517, 1023, 0, 517);
    endtask

    task automatic t_bypass();
        cfg_write(4'h7, 32'd0);
        px_exp("R3 mode0", 1023, 0, 517, 1023, 0, 517);
        cfg_write(4'h7, 32'd3);
        px_exp("R3 mode3", 12, 1000, 333, 12, 1000, 333);
    endtask

    task automatic t_bt709();
        logic [15:0] v [12];
        v = '{16'h3265, 16'h2000, 16'h0000, 16'hE6CE, 16'hF105, 16'h2000,
              16'hFA01, 16'h0A7D, 16'h0000, 16'h2000, 16'h3B61, 16'hE24F};
        for (int p = 0; p < 6; p++) cfg_write(4'(p), {v[2*p+1], v[2*p]});
        cfg_write(4'h7, 32'd1);
        px_exp("R12 R5 gray", 512, 512, 512, 512, 512, 512);
        px("R12 R5 mixed", 900, 300, 100);
        px("R12 R5 mixed2", 200, 700, 850);
        px_exp("R7 R12 clamp high", 1023, 1023, 0, OMAX,
               exp_row(1, 1, 1023, 1023, 0), exp_row(1, 2, 1023, 1023, 0));
        px_exp("R7 R12 clamp low", 0, 0, 0, 0,
               exp_row(1, 1, 0, 0, 0), 0);
    endtask

    task automatic t_round();
        cfg_write(4'h8, {16'h0000, 16'h1000});
        cfg_write(4'h9, 32'h0);
        cfg_write(4'hA, {16'h2000, 16'h0000});
        cfg_write(4'hB, {16'h0002, 16'h0000});
        cfg_write(4'hC, 32'h0);
        cfg_write(4'hD, {16'hF000, 16'h2000});
        cfg_write(4'h7, 32'd2);
        px_exp("R6 R5 half up a", 3, 7, 700, 2, 7, 188);
        px_exp("R6 R7 half up b", 5, 0, 100, 3, 0, 0);
        px_exp("R6 R4 half up c", 1, 1023, 1023, 1, 1023, 511);
    endtask

    task automatic t_ignored();
        cfg_write(4'h6, 32'hDEAD_BEEF);
        cfg_write(4'hE, 32'hBEEF_DEAD);
        cfg_write(4'hF, 32'h1234_5673);
        px_exp("R9 unused addr", 3, 7, 700, 2, 7, 188);
        cfg_write(4'h7, 32'd1);
        px("R9 set A kept", 900, 300, 100);
    endtask

    task automatic t_pair_order();
        cfg_write(4'h0, {16'h0000, 16'h2000});
        cfg_write(4'h1, {16'h0800, 16'h2000});
        px_exp("R8 pair halves", 10, 20, 30, 296,
               exp_row(1, 1, 10, 20, 30), exp_row(1, 2, 10, 20, 30));
    endtask

    task automatic t_stream();
        int a [16], b [16], c [16];
        for (int i = 0; i < 16; i++) begin
            a[i] = (i * 61 + 7) % 1024;
            b[i] = (i * 137 + 300) % 1024;
            c[i] = (1023 - i * 53) % 1024;
        end
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk("R2 stream ch0", int'(pix_out0), exp_row(cur_mode, 0, a[i-3], b[i-3], c[i-3]));
                chk("R2 stream ch1", int'(pix_out1), exp_row(cur_mode, 1, a[i-3], b[i-3], c[i-3]));
                chk("R2 stream ch2", int'(pix_out2), exp_row(cur_mode, 2, a[i-3], b[i-3], c[i-3]));
            end
            if (i < 16) begin
                pix_in0 = DW'(a[i]); pix_in1 = DW'(b[i]); pix_in2 = DW'(c[i]);
            end
        end
    endtask

    task automatic t_switch();
        int e [3][3];
        for (int r = 0; r < 3; r++) begin
            e[0][r] = exp_row(1, r, 200, 300, 400);
            e[1][r] = exp_row(1, r, 210, 310, 410);
            e[2][r] = exp_row(2, r, 220, 320, 420);
        end
        @(negedge clk);
        pix_in0 = 10'd200; pix_in1 = 10'd300; pix_in2 = 10'd400;
        @(negedge clk);
        pix_in0 = 10'd210; pix_in1 = 10'd310; pix_in2 = 10'd410;
        cfg_we = 1'b1; cfg_addr = 4'h7; cfg_wdata = 32'd2;
        @(negedge clk);
        cfg_we = 1'b0;
        pix_in0 = 10'd220; pix_in1 = 10'd320; pix_in2 = 10'd420;
        cur_mode = 2;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 switch ch0", int'(pix_out0), e[k][0]);
            chk("R11 switch ch1", int'(pix_out1), e[k][1]);
            chk("R11 switch ch2", int'(pix_out2), e[k][2]);
        end
    endtask

    initial begin
        for (int bk = 0; bk < 2; bk++)
            for (int k = 0; k < 12; k++)
                cf[bk][k] = (k % 5 == 0) ? 8192 : 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_bt709();
        t_round();
        t_ignored();
        t_pair_order();
        t_stream();
        t_switch();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule